// File: doc/BRIEF.md
# RGB to YCbCr Pixel Converter

This block turns a stream of packed RGB pixels into luma and two colour-difference values, one pixel per clock, using the BT.601 weightings in fixed-point arithmetic. Each channel weight is turned into an integer constant at elaboration time by scaling it with 2^FRAC_BITS (8192 by default) and rounding to the nearest integer. No multiplier or divider takes its operands at run time.

The work is split across two register stages. The first stage multiplies the three colour bytes by their constants and sums the products for each output channel. The second stage adds the mid-scale chroma bias and rounds on the most significant discarded fraction bit. It then drops the fraction and saturates the result into the byte range. A strobe travels beside the data, so the consumer knows which output cycles hold a converted pixel. The converter never stalls, and a new pixel may enter on every cycle.

Top module: `rgb_ycc_conv`

## Requirements
- R1: The input pixel is packed with red in bits [7:0], green in bits [15:8] and blue in bits [23:16].
- R2: Y equals 0.299·R + 0.587·G + 0.114·B, rounded and kept in 0..255, within one LSB of the real-valued result.
- R3: Cb equals −0.1687·R − 0.3313·G + 0.5·B + 128, rounded and kept in 0..255, within one LSB of the real-valued result.
- R4: Cr equals 0.5·R − 0.4187·G − 0.0813·B + 128, rounded and kept in 0..255, within one LSB of the real-valued result.
- R5: The output word holds Y in bits [7:0], Cb in bits [15:8] and Cr in bits [23:16]. A grey input with R = G = B = v gives exactly Y = v and Cb = Cr = 128.
- R6: Suppose `en` is sampled high at rising edge k. Then `ycc_valid` is high, and `ycc_out` holds that pixel's result, in the cycle that follows edge k+1, and in no other cycle on account of that pixel.
- R7: A result above 255 saturates to 255 and a result below 0 saturates to 0. Pure blue (0xFF0000) gives Cb = 255, and pure red (0x0000FF) gives Cr = 255.
- R8: While `rst` is high, `ycc_valid` is low from the next edge on. Pixels presented before or during reset never produce a `ycc_valid` pulse.
- R9: Pixels presented on consecutive cycles are all converted, with no gap or stall. Results appear in input order, one per cycle.
- R10: `ycc_valid` is never high for a cycle whose input had `en` low, whatever the pixel bus carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the strobe pipeline |
| en | input | 1 | Marks `pix_in` as a pixel to convert this cycle |
| pix_in | input | 3*PIX_W | Packed pixel {B, G, R} |
| ycc_out | output | 3*PIX_W | Packed result {Cr, Cb, Y} |
| ycc_valid | output | 1 | High when `ycc_out` carries a converted pixel |

## Verification
Every result is due exactly two rising edges after the edge that samples `en`. The scoreboard stamps each expected entry with the cycle number that falls due. When `ycc_valid` appears, it checks the arrival cycle against that stamp, and any pulse with no entry pending counts as a failure. Values are sampled on the falling edge, half a period after the output registers change. Reset and idle windows are checked only once the pipeline has had its two cycles to empty.

// File: rtl/ycc_pkg.sv
package ycc_pkg;

  localparam int NUM_CH  = 3;   // 0: Y, 1: Cb, 2: Cr
  localparam int NUM_TAP = 3;   // 0: R, 1: G, 2: B
  localparam int CH_Y    = 0;

  // Channel weight in units of 1e-4, signed.
  function automatic int weight_e4(input int ch, input int tap);
    int w;
    w = 0;
    case (ch)
      0: case (tap)
           0: w = 2990;
           1: w = 5870;
           default: w = 1140;
         endcase
      1: case (tap)
           0: w = -1687;
           1: w = -3313;
           default: w = 5000;
         endcase
      default: case (tap)
           0: w = 5000;
           1: w = -4187;
           default: w = -813;
         endcase
    endcase
    return w;
  endfunction

  // Weight scaled by 2^frac, rounded half away from zero.
  function automatic int fixed_coef(input int ch, input int tap, input int frac);
    longint w;
    longint mag;
    w   = longint'(weight_e4(ch, tap));
    mag = (((w < 0) ? -w : w) * (longint'(1) << frac) + 64'sd5000) / 64'sd10000;
    return int'((w < 0) ? -mag : mag);
  endfunction

  // Mid-scale chroma bias, already in the scaled domain.
  function automatic int chroma_bias(input int ch, input int pix_w, input int frac);
    return (ch == CH_Y) ? 0 : (1 << (pix_w - 1 + frac));
  endfunction

endpackage

// File: rtl/ycc_wsum.sv
module ycc_wsum
  import ycc_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int FRAC  = 13,
  parameter int ACC_W = 23,
  parameter int CH    = 0
) (
  input  logic                           clk,
  input  logic [NUM_TAP*PIX_W-1:0]       taps_in,
  output logic signed [ACC_W-1:0]        sum_q
);

  localparam int PAD = ACC_W - PIX_W;

  logic signed [ACC_W-1:0] prod [NUM_TAP];
  logic signed [ACC_W-1:0] acc;

  for (genvar t = 0; t < NUM_TAP; t++) begin : g_tap
    localparam logic signed [ACC_W-1:0] K = ACC_W'(fixed_coef(CH, t, FRAC));
    assign prod[t] = $signed({{PAD{1'b0}}, taps_in[t*PIX_W +: PIX_W]}) * K;
  end

  always_comb begin
    acc = '0;
    for (int t = 0; t < NUM_TAP; t++) begin
      acc = acc + prod[t];
    end
  end

  // Stage one: registered weighted sum.
  always_ff @(posedge clk) begin
    sum_q <= acc;
  end

endmodule

// File: rtl/ycc_round_sat.sv
module ycc_round_sat
  import ycc_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int FRAC  = 13,
  parameter int ACC_W = 23,
  parameter int CH    = 0
) (
  input  logic                    clk,
  input  logic signed [ACC_W-1:0] sum_in,
  output logic [PIX_W-1:0]        byte_q
);

  localparam logic signed [ACC_W-1:0] BIAS = ACC_W'(chroma_bias(CH, PIX_W, FRAC));
  localparam logic signed [ACC_W-1:0] TOP  = ACC_W'((1 << PIX_W) - 1);

  logic signed [ACC_W-1:0] biased;
  logic signed [ACC_W-1:0] whole;
  logic                    round_bit;

  assign biased    = sum_in + BIAS;
  assign round_bit = biased[FRAC-1];
  assign whole     = (biased >>> FRAC) + $signed({{(ACC_W-1){1'b0}}, round_bit});

  // Stage two: saturate into the byte range and register.
  always_ff @(posedge clk) begin
    if (whole < 0) begin
      byte_q <= '0;
    end else if (whole > TOP) begin
      byte_q <= '1;
    end else begin
      byte_q <= whole[PIX_W-1:0];
    end
  end

endmodule

// File: rtl/ycc_strobe_delay.sv
module ycc_strobe_delay #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_in,
  output logic strobe_out
);

  if (DEPTH == 1) begin : g_one
    logic sr;
    always_ff @(posedge clk) begin
      if (rst) sr <= 1'b0;
      else     sr <= strobe_in;
    end
    assign strobe_out = sr;
  end else begin : g_many
    logic [DEPTH-1:0] sr;
    always_ff @(posedge clk) begin
      if (rst) sr <= '0;
      else     sr <= {sr[DEPTH-2:0], strobe_in};
    end
    assign strobe_out = sr[DEPTH-1];
  end

  // R8: reset empties the strobe pipeline by the next edge.
  a_r8_reset_clears: assert property (@(posedge clk) rst |=> !strobe_out)
    else $error("a_r8_reset_clears");

endmodule

// File: rtl/rgb_ycc_conv.sv
module rgb_ycc_conv
  import ycc_pkg::*;
#(
  parameter int PIX_W     = 8,
  parameter int FRAC_BITS = 13
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic [3*PIX_W-1:0]   pix_in,
  output logic [3*PIX_W-1:0]   ycc_out,
  output logic                 ycc_valid
);

  localparam int ACC_W   = PIX_W + FRAC_BITS + 2;
  localparam int LATENCY = 2;

  logic signed [ACC_W-1:0] wsum   [NUM_CH];
  logic [PIX_W-1:0]        chan_q [NUM_CH];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    ycc_wsum #(
      .PIX_W(PIX_W), .FRAC(FRAC_BITS), .ACC_W(ACC_W), .CH(ch)
    ) u_wsum (
      .clk     (clk),
      .taps_in (pix_in),
      .sum_q   (wsum[ch])
    );

    ycc_round_sat #(
      .PIX_W(PIX_W), .FRAC(FRAC_BITS), .ACC_W(ACC_W), .CH(ch)
    ) u_round (
      .clk    (clk),
      .sum_in (wsum[ch]),
      .byte_q (chan_q[ch])
    );

    assign ycc_out[ch*PIX_W +: PIX_W] = chan_q[ch];
  end

  ycc_strobe_delay #(.DEPTH(LATENCY)) u_strobe (
    .clk        (clk),
    .rst        (rst),
    .strobe_in  (en),
    .strobe_out (ycc_valid)
  );

  // Checks on the assembled pipeline.
  localparam logic [PIX_W-1:0] MID  = PIX_W'(1 << (PIX_W - 1));
  localparam logic [PIX_W-1:0] FULL = '1;
  localparam logic [PIX_W-1:0] ZERO = '0;

  logic [1:0]       warm;
  logic [PIX_W-1:0] pr, pg, pb;

  assign pr = pix_in[PIX_W-1:0];
  assign pg = pix_in[2*PIX_W-1:PIX_W];
  assign pb = pix_in[3*PIX_W-1:2*PIX_W];

  always_ff @(posedge clk) begin
    if (rst)                warm <= '0;
    else if (warm != 2'd3)  warm <= warm + 2'd1;
  end

  // R6: strobe follows the sampled enable by exactly two edges.
  a_r6_latency: assert property (@(posedge clk) disable iff (rst)
    (warm >= 2'd2) |-> (ycc_valid == $past(en, 2)))
    else $error("a_r6_latency");

  // R5: grey input gives neutral chroma and unchanged luma, in {Cr,Cb,Y} order.
  a_r5_gray_neutral: assert property (@(posedge clk) disable iff (rst)
    ((warm >= 2'd2) && ($past(pr, 2) == $past(pg, 2)) && ($past(pg, 2) == $past(pb, 2)))
      |-> (ycc_out == {MID, MID, $past(pr, 2)}))
    else $error("a_r5_gray_neutral");

  // R7: pure blue saturates Cb at full scale.
  a_r7_blue_clip: assert property (@(posedge clk) disable iff (rst)
    ((warm >= 2'd2) && ($past(pix_in, 2) == {FULL, ZERO, ZERO}))
      |-> (ycc_out[2*PIX_W-1:PIX_W] == FULL))
    else $error("a_r7_blue_clip");

  // R7: pure red saturates Cr at full scale.
  a_r7_red_clip: assert property (@(posedge clk) disable iff (rst)
    ((warm >= 2'd2) && ($past(pix_in, 2) == {ZERO, ZERO, FULL}))
      |-> (ycc_out[3*PIX_W-1:2*PIX_W] == FULL))
    else $error("a_r7_red_clip");

endmodule

// File: tb/rgb_ycc_conv_bench.sv
module rgb_ycc_conv_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic [23:0] pix = '0;
  logic [23:0] ycc;
  logic        vld;

  rgb_ycc_conv u_rgb_ycc_conv (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .pix_in    (pix),
    .ycc_out   (ycc),
    .ycc_valid (vld)
  );

  always #4 clk = ~clk;  // 125 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  typedef struct {
    int          ey;
    int          ecb;
    int          ecr;
    int          due;
    logic [23:0] px;
  } exp_t;

  exp_t sb[$];
  exp_t cur;
  int   ay, acb, acr;

  function automatic int to_byte(input real v);
    int k;
    if (v <= 0.0) return 0;
    k = $rtoi(v + 0.5);
    if (k > 255) k = 255;
    return k;
  endfunction

  function automatic int absd(input int a, input int b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic put_pixel(input logic [7:0] r, input logic [7:0] g,
                           input logic [7:0] b, input bit track);
    exp_t e;
    real rr, rg, rb;
    @(negedge clk);
    en  = 1'b1;
    pix = {b, g, r};
    if (track) begin
      rr = real'(r); rg = real'(g); rb = real'(b);
      e.ey  = to_byte(0.299 * rr + 0.587 * rg + 0.114 * rb);
      e.ecb = to_byte(-0.1687 * rr - 0.3313 * rg + 0.5 * rb + 128.0);
      e.ecr = to_byte(0.5 * rr - 0.4187 * rg - 0.0813 * rb + 128.0);
      e.due = cyc + 2;
      e.px  = {b, g, r};
      sb.push_back(e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      en  = 1'b0;
      pix = 24'($urandom);
    end
  endtask

  task automatic quiet_check(input int n, input string req);
    repeat (n) begin
      @(negedge clk);
      en  = 1'b0;
      pix = 24'($urandom);
      check(vld == 1'b0, req, "ycc_valid in quiet window", int'(vld), 0);
    end
  endtask

  task automatic wrap_up();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && !finished && vld) begin
      if (sb.size() == 0) begin
        check(1'b0, "R10", "ycc_valid with nothing pending", 1, 0);
      end else begin
        cur = sb.pop_front();
        ay  = int'(ycc[7:0]);
        acb = int'(ycc[15:8]);
        acr = int'(ycc[23:16]);
        check(cyc == cur.due, "R6", "result arrival cycle", cyc, cur.due);
        check(absd(ay, cur.ey) <= 1, "R1,R2", "Y", ay, cur.ey);
        check(absd(acb, cur.ecb) <= 1, "R3", "Cb", acb, cur.ecb);
        check(absd(acr, cur.ecr) <= 1, "R4", "Cr", acr, cur.ecr);
        if (cur.px[7:0] == cur.px[15:8] && cur.px[15:8] == cur.px[23:16])
          check(ycc == {8'd128, 8'd128, cur.px[7:0]}, "R5", "grey packed word",
                int'(ycc), int'({8'd128, 8'd128, cur.px[7:0]}));
        if (cur.px == 24'hFF0000)
          check(acb == 255, "R7", "Cb of pure blue", acb, 255);
        if (cur.px == 24'h0000FF)
          check(acr == 255, "R7", "Cr of pure red", acr, 255);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL R9 watchdog: actual %0d expected %0d", cyc, 0);
      wrap_up();
    end
  end

  // Stimulus
  initial begin
    // R8: enable asserted during reset must not leak out
    en  = 1'b1;
    pix = 24'h123456;
    repeat (3) begin
      @(negedge clk);
      pix = 24'($urandom);
      check(vld == 1'b0, "R8", "ycc_valid during reset", int'(vld), 0);
    end
    @(negedge clk);
    rst = 1'b0;
    en  = 1'b0;
    quiet_check(4, "R8");

    // Corner pixels, spaced apart (R1..R5, R7)
    put_pixel(8'h00, 8'h00, 8'h00, 1'b1); idle(3);
    put_pixel(8'hFF, 8'hFF, 8'hFF, 1'b1); idle(3);
    put_pixel(8'hFF, 8'h00, 8'h00, 1'b1); idle(3);
    put_pixel(8'h00, 8'hFF, 8'h00, 1'b1); idle(3);
    put_pixel(8'h00, 8'h00, 8'hFF, 1'b1); idle(3);
    put_pixel(8'h80, 8'h80, 8'h80, 1'b1); idle(3);
    put_pixel(8'h40, 8'h40, 8'h40, 1'b1); idle(3);
    put_pixel(8'h00, 8'hFF, 8'hFF, 1'b1); idle(3);

    // R9: back-to-back burst, including corner pixels mid-stream
    for (int i = 0; i < 24; i++) begin
      put_pixel(8'($urandom), 8'($urandom), 8'($urandom), 1'b1);
    end
    put_pixel(8'hFF, 8'h00, 8'h00, 1'b1);
    put_pixel(8'h00, 8'h00, 8'hFF, 1'b1);
    put_pixel(8'h11, 8'h11, 8'h11, 1'b1);

    // R10: enable low with a busy pixel bus
    idle(3);
    quiet_check(6, "R10");

    // R8: reset right after a pixel is taken discards it
    put_pixel(8'hAA, 8'h55, 8'h33, 1'b0);
    @(negedge clk);
    en  = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    quiet_check(4, "R8");

    // Mixed gaps
    for (int i = 0; i < 16; i++) begin
      put_pixel(8'($urandom), 8'($urandom), 8'($urandom), 1'b1);
      if (($urandom % 3) == 0) idle(1 + int'($urandom % 3));
    end

    idle(4);
    check(sb.size() == 0, "R9", "results still pending", sb.size(), 0);
    wrap_up();
  end

endmodule